// File: doc/BRIEF.md
# In-System Programming Target Command Engine

This block is the target end of a four-wire serial programming link. While the
programming request input is high, the engine decodes fixed four-byte frames
arriving on `mosi` and answers on `miso`. It stays locked until a valid unlock
frame arrives. After that it accepts byte loads into a word-wide page buffer,
commits the whole buffer to a flash-like word array in one step, reads that
array back, and writes or reads single bytes of a small byte array that models
non-volatile data storage.

Each write starts an internal busy window whose length is set in clock cycles.
While that window is open, reads that fall in the affected region return 0xFF.
A host can therefore poll for completion. The serial link is oversampled by the
system clock in mode 0: the target samples on the rising SCK edge, changes MISO
on the falling edge, and sends the MSB first.

A frame is: byte 0 opcode, byte 1 address high, byte 2 address low, byte 3 data.
The 16-bit address is the concatenation of bytes 1 and 2. During byte 2 of every
frame, `miso` returns byte 1 of the same frame. During byte 3 of a read, `miso`
returns the read data. Otherwise each byte returns the byte received just before
it.

Top module: `isp_target_engine`

## Requirements
- R1: While `prog_req` is low, the frame position is held at byte 0, the engine is locked, and `miso` is 0. Raising `prog_req` starts a fresh frame in the locked state.
- R2: The frame 0xAC, 0x53, any, any unlocks the engine. While the engine is locked, every other frame leaves both arrays unchanged, and so does an unlock frame whose second byte is not 0x53.
- R3: During byte 2 of every frame, `miso` shifts out byte 1 of that frame, MSB first, in both the locked and the unlocked state.
- R4: Opcode 0x40 writes byte 3 into the low byte of page-buffer word addr[6:0]. Opcode 0x48 writes the high byte. Each opcode leaves the other byte of the word unchanged.
- R5: Opcode 0x4C copies the whole page buffer into array page addr[15:7], taken modulo the page count, in one step. Other pages are left unchanged.
- R6: Opcode 0x20 returns the low byte and opcode 0x28 the high byte of the word at address addr. Word index addr[6:0] selects the word inside page addr[15:7]. The data appears on `miso` during byte 3.
- R7: For PAGE_BUSY_CYC cycles after a commit, word reads from the committed page return 0xFF. Reads from other pages return their stored data. After the window closes, the committed data reads back.
- R8: Opcode 0xC0 writes byte 3 to byte-array location addr, taken modulo the depth. Opcode 0xA0 returns that location during byte 3.
- R9: For EE_BUSY_CYC cycles after a byte-array write, reads of that location return 0xFF. Other locations read normally.
- R10: After `rst_n` every location in both arrays and in the page buffer reads 0xFF.
- R11: Lowering `prog_req` in the middle of a frame discards the partial frame. The next frame must be an unlock frame starting at byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | High holds the engine in programming mode |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The hardest case to reach is a read that lands inside a busy window while the
region next to it holds data that must still read normally. The stimulus first
programs one page and one byte location. It waits out their windows, then
commits a different page or writes a different location. The reads are issued
back to back, so the address phase of the first read completes a few hundred
cycles into the shortened busy window. Lock checks send writes while locked and
then read after any busy window would have closed, so a wrongly accepted write
cannot hide behind the 0xFF of a busy window.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_UNLOCK0 = 8'hAC;
  localparam logic [7:0] OP_UNLOCK1 = 8'h53;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_COMMIT  = 8'h4C;
  localparam logic [7:0] OP_READ_LO = 8'h20;
  localparam logic [7:0] OP_READ_HI = 8'h28;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_FLO  = 2'd1,
    RD_FHI  = 2'd2,
    RD_EE   = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/isp_link.sv
module isp_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       prog_req,
  input  logic [7:0] tx_next,
  output logic       miso,
  output logic       prog_mode,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [2:0] sck_sr;
  logic [1:0] mosi_sr;
  logic [1:0] prog_sr;
  logic       sck_rise, sck_fall, mosi_s;

  logic [2:0] bit_cnt, bit_cnt_d;
  logic [6:0] rx_sh, rx_sh_d;
  logic [7:0] tx_sh, tx_sh_d;
  logic [7:0] hold, hold_d;
  logic       pend, pend_d;
  logic       done_d;
  logic [7:0] rx_q_d;

  // input synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr  <= '0;
      mosi_sr <= '0;
      prog_sr <= '0;
    end else begin
      sck_sr  <= {sck_sr[1:0], sck};
      mosi_sr <= {mosi_sr[0], mosi};
      prog_sr <= {prog_sr[0], prog_req};
    end
  end

  assign sck_rise  = sck_sr[1] & ~sck_sr[2];
  assign sck_fall  = ~sck_sr[1] & sck_sr[2];
  assign mosi_s    = mosi_sr[1];
  assign prog_mode = prog_sr[1];
  assign miso      = tx_sh[7];

  always_comb begin
    bit_cnt_d = bit_cnt;
    rx_sh_d   = rx_sh;
    tx_sh_d   = tx_sh;
    hold_d    = hold;
    pend_d    = pend;
    done_d    = 1'b0;
    rx_q_d    = rx_byte;
    if (!prog_mode) begin
      bit_cnt_d = '0;
      pend_d    = 1'b0;
      tx_sh_d   = '0;
    end else begin
      if (sck_rise) begin
        rx_sh_d   = {rx_sh[5:0], mosi_s};
        bit_cnt_d = bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          done_d = 1'b1;
          rx_q_d = {rx_sh, mosi_s};
        end
      end
      if (sck_fall) begin
        if (pend) begin
          tx_sh_d = hold;
          pend_d  = 1'b0;
        end else begin
          tx_sh_d = {tx_sh[6:0], 1'b0};
        end
      end
      if (byte_done) begin
        hold_d = tx_next;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      hold      <= '0;
      pend      <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      bit_cnt   <= bit_cnt_d;
      rx_sh     <= rx_sh_d;
      tx_sh     <= tx_sh_d;
      hold      <= hold_d;
      pend      <= pend_d;
      byte_done <= done_d;
      rx_byte   <= rx_q_d;
    end
  end
endmodule

// File: rtl/isp_cmd.sv
module isp_cmd
  import isp_pkg::*;
#(
  parameter int PAGE_AW = 7,
  parameter int PG_W    = 2,
  parameter int EE_AW   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_mode,
  input  logic               byte_done,
  input  logic [7:0]         rx_byte,
  input  logic [7:0]         rd_data,
  output logic [7:0]         tx_next,
  output logic [1:0]         byte_idx,
  output logic               enabled,
  output logic               ld_we,
  output logic               ld_hi,
  output logic [PAGE_AW-1:0] ld_word,
  output logic [7:0]         wr_data,
  output logic               pg_commit,
  output logic [PG_W-1:0]    pg_sel,
  output logic               ee_we,
  output logic [EE_AW-1:0]   ee_addr,
  output rd_kind_e           rd_kind,
  output logic [PG_W-1:0]    rd_pg,
  output logic [PAGE_AW-1:0] rd_word,
  output logic [EE_AW-1:0]   rd_ea
);
  logic [1:0]  byte_idx_d;
  logic        enabled_d;
  logic [7:0]  op_q, op_d, hi_q, hi_d, lo_q, lo_d;
  logic [15:0] cmd_addr, rd_addr;
  logic        exec;
  logic        unused_addr_bits;

  assign cmd_addr = {hi_q, lo_q};
  assign rd_addr  = {hi_q, rx_byte};
  assign unused_addr_bits = ^{cmd_addr, rd_addr};

  assign exec      = byte_done && (byte_idx == 2'd3) && enabled;
  assign ld_we     = exec && ((op_q == OP_LOAD_LO) || (op_q == OP_LOAD_HI));
  assign ld_hi     = (op_q == OP_LOAD_HI);
  assign ld_word   = lo_q[PAGE_AW-1:0];
  assign wr_data   = rx_byte;
  assign pg_commit = exec && (op_q == OP_COMMIT);
  assign pg_sel    = cmd_addr[PAGE_AW +: PG_W];
  assign ee_we     = exec && (op_q == OP_EE_WR);
  assign ee_addr   = cmd_addr[EE_AW-1:0];
  assign rd_pg     = rd_addr[PAGE_AW +: PG_W];
  assign rd_word   = rd_addr[PAGE_AW-1:0];
  assign rd_ea     = rd_addr[EE_AW-1:0];

  always_comb begin
    case (op_q)
      OP_READ_LO: rd_kind = RD_FLO;
      OP_READ_HI: rd_kind = RD_FHI;
      OP_EE_RD:   rd_kind = RD_EE;
      default:    rd_kind = RD_NONE;
    endcase
  end

  // byte 3 carries read data; every other byte carries the previous one
  assign tx_next = (enabled && (byte_idx == 2'd2) && (rd_kind != RD_NONE))
                   ? rd_data : rx_byte;

  always_comb begin
    byte_idx_d = byte_idx;
    enabled_d  = enabled;
    op_d       = op_q;
    hi_d       = hi_q;
    lo_d       = lo_q;
    if (!prog_mode) begin
      byte_idx_d = 2'd0;
      enabled_d  = 1'b0;
    end else if (byte_done) begin
      byte_idx_d = byte_idx + 2'd1;
      case (byte_idx)
        2'd0: op_d = rx_byte;
        2'd1: hi_d = rx_byte;
        2'd2: lo_d = rx_byte;
        default: begin
          if ((op_q == OP_UNLOCK0) && (hi_q == OP_UNLOCK1)) enabled_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx <= 2'd0;
      enabled  <= 1'b0;
      op_q     <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      byte_idx <= byte_idx_d;
      enabled  <= enabled_d;
      op_q     <= op_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
    end
  end
endmodule

// File: rtl/isp_store.sv
module isp_store
  import isp_pkg::*;
#(
  parameter int PAGE_AW       = 7,
  parameter int FLASH_PAGES   = 4,
  parameter int EE_DEPTH      = 64,
  parameter int PAGE_BUSY_CYC = 40000,
  parameter int EE_BUSY_CYC   = 20000,
  localparam int PAGE_WORDS   = 1 << PAGE_AW,
  localparam int PG_W         = $clog2(FLASH_PAGES),
  localparam int EE_AW        = $clog2(EE_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_we,
  input  logic               ld_hi,
  input  logic [PAGE_AW-1:0] ld_word,
  input  logic [7:0]         wr_data,
  input  logic               pg_commit,
  input  logic [PG_W-1:0]    pg_sel,
  input  logic               ee_we,
  input  logic [EE_AW-1:0]   ee_addr,
  input  rd_kind_e           rd_kind,
  input  logic [PG_W-1:0]    rd_pg,
  input  logic [PAGE_AW-1:0] rd_word,
  input  logic [EE_AW-1:0]   rd_ea,
  output logic [7:0]         rd_data,
  output logic               pg_busy,
  output logic               ee_busy
);
  localparam int PG_CW = $clog2(PAGE_BUSY_CYC + 1);
  localparam int EE_CW = $clog2(EE_BUSY_CYC + 1);

  logic [15:0] pbuf  [PAGE_WORDS];
  logic [15:0] flash [FLASH_PAGES][PAGE_WORDS];
  logic [7:0]  eemem [EE_DEPTH];

  logic [PG_CW-1:0] pg_cnt, pg_cnt_d;
  logic [EE_CW-1:0] ee_cnt, ee_cnt_d;
  logic [PG_W-1:0]  busy_pg, busy_pg_d;
  logic [EE_AW-1:0] busy_ea, busy_ea_d;
  logic             flash_rd;

  // page buffer with per-byte lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < PAGE_WORDS; w++) pbuf[w] <= 16'hFFFF;
    end else if (ld_we) begin
      if (ld_hi) pbuf[ld_word][15:8] <= wr_data;
      else       pbuf[ld_word][7:0]  <= wr_data;
    end
  end

  // whole-page copy in one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < FLASH_PAGES; p++)
        for (int w = 0; w < PAGE_WORDS; w++) flash[p][w] <= 16'hFFFF;
    end else if (pg_commit) begin
      flash[pg_sel] <= pbuf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < EE_DEPTH; a++) eemem[a] <= 8'hFF;
    end else if (ee_we) begin
      eemem[ee_addr] <= wr_data;
    end
  end

  // busy windows
  always_comb begin
    pg_cnt_d  = pg_cnt;
    busy_pg_d = busy_pg;
    ee_cnt_d  = ee_cnt;
    busy_ea_d = busy_ea;
    if (pg_commit) begin
      pg_cnt_d  = PG_CW'(PAGE_BUSY_CYC);
      busy_pg_d = pg_sel;
    end else if (pg_cnt != '0) begin
      pg_cnt_d = pg_cnt - 1'b1;
    end
    if (ee_we) begin
      ee_cnt_d  = EE_CW'(EE_BUSY_CYC);
      busy_ea_d = ee_addr;
    end else if (ee_cnt != '0) begin
      ee_cnt_d = ee_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_cnt  <= '0;
      busy_pg <= '0;
      ee_cnt  <= '0;
      busy_ea <= '0;
    end else begin
      pg_cnt  <= pg_cnt_d;
      busy_pg <= busy_pg_d;
      ee_cnt  <= ee_cnt_d;
      busy_ea <= busy_ea_d;
    end
  end

  assign pg_busy  = (pg_cnt != '0);
  assign ee_busy  = (ee_cnt != '0);
  assign flash_rd = (rd_kind == RD_FLO) || (rd_kind == RD_FHI);

  always_comb begin
    case (rd_kind)
      RD_FLO:  rd_data = flash[rd_pg][rd_word][7:0];
      RD_FHI:  rd_data = flash[rd_pg][rd_word][15:8];
      RD_EE:   rd_data = eemem[rd_ea];
      default: rd_data = 8'hFF;
    endcase
    if (flash_rd && pg_busy && (rd_pg == busy_pg)) rd_data = 8'hFF;
    if ((rd_kind == RD_EE) && ee_busy && (rd_ea == busy_ea)) rd_data = 8'hFF;
  end
endmodule

// File: rtl/isp_target_engine.sv
module isp_target_engine
  import isp_pkg::*;
#(
  parameter int PAGE_AW       = 7,
  parameter int FLASH_PAGES   = 4,
  parameter int EE_DEPTH      = 64,
  parameter int PAGE_BUSY_CYC = 40000,
  parameter int EE_BUSY_CYC   = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_req,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int PG_W  = $clog2(FLASH_PAGES);
  localparam int EE_AW = $clog2(EE_DEPTH);

  logic               prog_mode, byte_done, enabled;
  logic [7:0]         rx_byte, tx_next, rd_data, wr_data;
  logic [1:0]         byte_idx;
  logic               ld_we, ld_hi, pg_commit, ee_we, pg_busy, ee_busy;
  logic [PAGE_AW-1:0] ld_word, rd_word;
  logic [PG_W-1:0]    pg_sel, rd_pg;
  logic [EE_AW-1:0]   ee_addr, rd_ea;
  rd_kind_e           rd_kind;

  isp_link u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .prog_req(prog_req),
    .tx_next(tx_next), .miso(miso), .prog_mode(prog_mode),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  isp_cmd #(.PAGE_AW(PAGE_AW), .PG_W(PG_W), .EE_AW(EE_AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_data(rd_data), .tx_next(tx_next),
    .byte_idx(byte_idx), .enabled(enabled), .ld_we(ld_we), .ld_hi(ld_hi),
    .ld_word(ld_word), .wr_data(wr_data), .pg_commit(pg_commit),
    .pg_sel(pg_sel), .ee_we(ee_we), .ee_addr(ee_addr), .rd_kind(rd_kind),
    .rd_pg(rd_pg), .rd_word(rd_word), .rd_ea(rd_ea)
  );

  isp_store #(
    .PAGE_AW(PAGE_AW), .FLASH_PAGES(FLASH_PAGES), .EE_DEPTH(EE_DEPTH),
    .PAGE_BUSY_CYC(PAGE_BUSY_CYC), .EE_BUSY_CYC(EE_BUSY_CYC)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_hi(ld_hi), .ld_word(ld_word),
    .wr_data(wr_data), .pg_commit(pg_commit), .pg_sel(pg_sel), .ee_we(ee_we),
    .ee_addr(ee_addr), .rd_kind(rd_kind), .rd_pg(rd_pg), .rd_word(rd_word),
    .rd_ea(rd_ea), .rd_data(rd_data), .pg_busy(pg_busy), .ee_busy(ee_busy)
  );
endmodule

// File: rtl/isp_target_sva.sv
module isp_target_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_mode,
  input logic       byte_done,
  input logic [1:0] byte_idx,
  input logic       enabled,
  input logic       ld_we,
  input logic       pg_commit,
  input logic       ee_we,
  input logic       pg_busy,
  input logic       ee_busy,
  input logic       miso
);
  AST_IDLE_OUTSIDE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> (byte_idx == 2'd0) && !enabled); // R1

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> !miso); // R1

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !(ld_we || pg_commit || ee_we)); // R2

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && byte_done) |=> (byte_idx == $past(byte_idx) + 2'd1)); // R3

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pg_commit |=> pg_busy); // R7

  AST_EE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ee_we |=> ee_busy); // R9
endmodule

bind isp_target_engine isp_target_sva u_sva (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .byte_done(byte_done),
  .byte_idx(byte_idx), .enabled(enabled), .ld_we(ld_we),
  .pg_commit(pg_commit), .ee_we(ee_we), .pg_busy(pg_busy),
  .ee_busy(ee_busy), .miso(miso)
);

// File: tb/isp_target_engine_tb.sv
module isp_target_engine_tb;
  localparam int H      = 10;
  localparam int PG_BSY = 1500;
  localparam int EE_BSY = 1000;

  logic clk, rst_n, prog_req, sck, mosi, miso;
  int   n_checks = 0;
  int   n_fail   = 0;

  isp_target_engine #(.PAGE_BUSY_CYC(PG_BSY), .EE_BUSY_CYC(EE_BSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .sck(sck), .mosi(mosi),
    .miso(miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(H);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3,
                       output logic [7:0] r2, output logic [7:0] r3);
    logic [7:0] d;
    xfer(b0, d);
    xfer(b1, d);
    xfer(b2, r2);
    xfer(b3, r3);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // reset state: miso low, arrays erased after unlock
  task automatic t_reset;
    logic [7:0] r2, r3;
    chk("R1 miso low after reset", {7'd0, miso}, 8'h00);
    // locked traffic must not write anything (R2)
    frame(8'h40, 8'h00, 8'h00, 8'h11, r2, r3);
    frame(8'h4C, 8'h00, 8'h00, 8'h00, r2, r3);
    frame(8'hC0, 8'h00, 8'h05, 8'h22, r2, r3);
    // bad unlock: echo still works (R3), stays locked
    frame(8'hAC, 8'h52, 8'h00, 8'h00, r2, r3);
    chk("R3 echo of byte1 while locked", r2, 8'h52);
    frame(8'hC0, 8'h00, 8'h05, 8'h33, r2, r3);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    chk("R2 unlock echo 0x53", r2, 8'h53);
    wait_clk(PG_BSY + 100);
    frame(8'h20, 8'h00, 8'h00, 8'h00, r2, r3);
    chk("R2/R10 locked page write ignored", r3, 8'hFF);
    frame(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    chk("R2/R10 locked byte write ignored", r3, 8'hFF);
    frame(8'h28, 8'h01, 8'h23, 8'h00, r2, r3);
    chk("R10 erased word high", r3, 8'hFF);
  endtask

  task automatic t_page;
    logic [7:0] r2, r3;
    frame(8'h40, 8'h00, 8'h03, 8'h34, r2, r3);
    frame(8'h48, 8'h00, 8'h03, 8'h12, r2, r3);
    frame(8'h4C, 8'h00, 8'h00, 8'h00, r2, r3);
    wait_clk(PG_BSY + 100);
    frame(8'h20, 8'h00, 8'h03, 8'h00, r2, r3);
    chk("R6 read low page0 w3", r3, 8'h34);
    frame(8'h28, 8'h00, 8'h03, 8'h00, r2, r3);
    chk("R6 read high page0 w3", r3, 8'h12);
    // only the low lane of w3 changes; w127 gets only a low byte
    frame(8'h40, 8'h00, 8'h03, 8'h56, r2, r3);
    frame(8'h40, 8'h00, 8'h7F, 8'hCD, r2, r3);
    frame(8'h4C, 8'h00, 8'h80, 8'h00, r2, r3);
    frame(8'h20, 8'h00, 8'h83, 8'h00, r2, r3);
    chk("R7 busy page reads FF", r3, 8'hFF);
    frame(8'h28, 8'h00, 8'h03, 8'h00, r2, r3);
    chk("R7 other page readable while busy", r3, 8'h12);
    wait_clk(PG_BSY + 100);
    frame(8'h20, 8'h00, 8'h83, 8'h00, r2, r3);
    chk("R7 page1 w3 low after busy", r3, 8'h56);
    frame(8'h28, 8'h00, 8'h83, 8'h00, r2, r3);
    chk("R4 high lane kept", r3, 8'h12);
    frame(8'h20, 8'h00, 8'hFF, 8'h00, r2, r3);
    chk("R4 w127 low", r3, 8'hCD);
    frame(8'h28, 8'h00, 8'hFF, 8'h00, r2, r3);
    chk("R4 w127 high untouched", r3, 8'hFF);
    frame(8'h20, 8'h00, 8'h03, 8'h00, r2, r3);
    chk("R5 page0 unchanged by page1 commit", r3, 8'h34);
    // page 5 wraps to page 1 with four pages
    frame(8'h28, 8'h02, 8'h83, 8'h00, r2, r3);
    chk("R5 page index modulo count", r3, 8'h12);
  endtask

  task automatic t_eeprom;
    logic [7:0] r2, r3;
    frame(8'hC0, 8'h00, 8'h06, 8'hA6, r2, r3);
    wait_clk(EE_BSY + 100);
    frame(8'hC0, 8'h00, 8'h05, 8'h5A, r2, r3);
    frame(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    chk("R9 busy location reads FF", r3, 8'hFF);
    frame(8'hA0, 8'h00, 8'h06, 8'h00, r2, r3);
    chk("R9 other location normal", r3, 8'hA6);
    wait_clk(EE_BSY + 100);
    frame(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    chk("R8 byte readback", r3, 8'h5A);
    frame(8'hA0, 8'h01, 8'h06, 8'h00, r2, r3);
    chk("R8 address modulo depth", r3, 8'hA6);
  endtask

  task automatic t_relock;
    logic [7:0] r2, r3, d;
    xfer(8'hC0, d);
    xfer(8'h00, d);
    prog_req = 1'b0;
    wait_clk(20);
    chk("R1 miso low outside programming", {7'd0, miso}, 8'h00);
    prog_req = 1'b1;
    wait_clk(20);
    frame(8'hC0, 8'h00, 8'h07, 8'h77, r2, r3);
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    chk("R11 realigned unlock echo", r2, 8'h53);
    wait_clk(EE_BSY + 100);
    frame(8'hA0, 8'h00, 8'h07, 8'h00, r2, r3);
    chk("R11 write before unlock ignored", r3, 8'hFF);
  endtask

  initial begin
    wait_clk(190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    prog_req = 1'b0;
    sck      = 1'b0;
    mosi     = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    prog_req = 1'b1;
    wait_clk(10);
    t_reset();
    t_page();
    t_eeprom();
    t_relock();
    summary();
    $finish;
  end
endmodule